// File: doc/BRIEF.md
# Rotating Function Unit with Skip Test

This block is the execution stage of a small word-oriented processor core. Each cycle it receives two 32-bit operands and three selects. It applies one arithmetic or logic function to the operands. It can then rotate that result to the right. Finally it tests the rotated word to decide whether the core should skip its next instruction.

Both the final word and the skip flag are captured in output registers. They are valid one clock after the inputs are presented. Register access, writeback choice and branching are handled by the surrounding core.

A single adder serves add, subtract, increment and decrement. The operand and carry feeding it are chosen from the decoded function. A bank of fixed rotations follows the function stage, and a sign and zero test follows the rotation.

Top module: `rotSkipUnit`

## Requirements
- R1: While rstN is low, result and skipNext are held at zero.
- R2: Outputs are registered. The inputs present at a rising edge set result and skipNext after that edge, and the outputs hold until the next edge.
- R3: funcSel 0 gives opA+opB, 1 gives opA-opB and 2 gives opA&opB. All arithmetic wraps modulo 2^32.
- R4: funcSel 3 gives opA+1 and funcSel 4 gives opA-1. The value of opB has no effect on either.
- R5: rotSel 0 leaves the function result unrotated. rotSel 1, 2 and 3 rotate it right by 1, 8 and 16 bits. An operand of 1 rotated by 1 gives 32'h8000_0000.
- R6: skipSel 1 sets skipNext exactly when bit 31 of the rotated result is 1, which means the result is negative in two's complement.
- R7: skipSel 2 sets skipNext exactly when the rotated result equals zero.
- R8: skipSel 0 and skipSel 3 never set skipNext.
- R9: funcSel 5, 6 and 7 give a zero result and never set skipNext, whatever the rotate and skip selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, used by add, subtract and and only |
| funcSel | input | 3 | Function select (see R3, R4, R9) |
| rotSel | input | 2 | Rotate select (see R5) |
| skipSel | input | 2 | Skip-condition select (see R6 to R8) |
| result | output | 32 | Registered, rotated function result |
| skipNext | output | 1 | Registered skip-next flag |

## Verification
The assertions check four things on every cycle:
- the sign and zero skip tests against the registered result;
- the silence of the never-skip selects and the unused functions;
- the unrotated and, increment and decrement results against the operands of the previous cycle;
- the zero state during reset.

Only the bench's sweep shows the rest:
- that each rotation amount moves the bits correctly;
- that subtraction and wraparound give the right words;
- that increment and decrement really ignore opB under every rotation and skip select;
- that the outputs hold steady between edges.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_INC = 3'd3,
    FN_DEC = 3'd4
  } rsuFunc_e;

  typedef enum logic [1:0] {
    SK_NEVER = 2'd0,
    SK_NEG   = 2'd1,
    SK_ZERO  = 2'd2,
    SK_RSVD  = 2'd3
  } rsuSkip_e;

  localparam int ROT_CHOICES = 4;

  // Control strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic       useAnd;
    logic       invertB;
    logic       constOne;
    logic       constAllOnes;
    logic       carryIn;
    logic       funcValid;
    logic [1:0] rotIdx;
    logic       chkNeg;
    logic       chkZero;
  } rsuStrobes_t;
endpackage

// File: rtl/rsuCtrl.sv
module rsuCtrl
  import rsu_pkg::*;
(
  input  logic [2:0]  funcSel,
  input  logic [1:0]  rotSel,
  input  logic [1:0]  skipSel,
  output rsuStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.rotIdx = rotSel;
    unique case (funcSel)
      FN_ADD: strobes.funcValid = 1'b1;
      FN_SUB: begin
        strobes.funcValid = 1'b1;
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
      end
      FN_AND: begin
        strobes.funcValid = 1'b1;
        strobes.useAnd    = 1'b1;
      end
      FN_INC: begin
        strobes.funcValid = 1'b1;
        strobes.constOne  = 1'b1;
      end
      FN_DEC: begin
        strobes.funcValid    = 1'b1;
        strobes.constAllOnes = 1'b1;
      end
      default: strobes.funcValid = 1'b0;
    endcase
    strobes.chkNeg  = strobes.funcValid && (skipSel == SK_NEG);
    strobes.chkZero = strobes.funcValid && (skipSel == SK_ZERO);
  end
endmodule

// File: rtl/rsuDatapath.sv
module rsuDatapath
  import rsu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  rsuStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              skipNext
);
  localparam int ROT_SMALL = 1;
  localparam int ROT_MID   = 8;
  localparam int ROT_LARGE = 16;

  logic [DATA_W-1:0] addB;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] funcVal;
  logic [DATA_W-1:0] rotCand [ROT_CHOICES];
  logic [DATA_W-1:0] rotVal;
  logic              skipVal;

  // One shared adder serves add, subtract, increment and decrement.
  always_comb begin
    if (strobes.constOne)          addB = {{(DATA_W-1){1'b0}}, 1'b1};
    else if (strobes.constAllOnes) addB = {DATA_W{1'b1}};
    else if (strobes.invertB)      addB = ~opB;
    else                           addB = opB;
    sumVal = opA + addB + {{(DATA_W-1){1'b0}}, strobes.carryIn};
    if (!strobes.funcValid)  funcVal = '0;
    else if (strobes.useAnd) funcVal = opA & opB;
    else                     funcVal = sumVal;
  end

  for (genvar gi = 0; gi < ROT_CHOICES; gi++) begin : g_rot
    localparam int AMT = (gi == 0) ? 0 : (gi == 1) ? ROT_SMALL :
                         (gi == 2) ? ROT_MID : ROT_LARGE;
    if (AMT == 0) begin : g_none
      assign rotCand[gi] = funcVal;
    end else begin : g_shift
      assign rotCand[gi] = {funcVal[AMT-1:0], funcVal[DATA_W-1:AMT]};
    end
  end

  always_comb begin
    rotVal  = rotCand[strobes.rotIdx];
    skipVal = (strobes.chkNeg  && rotVal[DATA_W-1]) ||
              (strobes.chkZero && (rotVal == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      skipNext <= 1'b0;
    end else begin
      result   <= rotVal;
      skipNext <= skipVal;
    end
  end
endmodule

// File: rtl/rotSkipUnit.sv
module rotSkipUnit
  import rsu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        funcSel,
  input  logic [1:0]        rotSel,
  input  logic [1:0]        skipSel,
  output logic [DATA_W-1:0] result,
  output logic              skipNext
);
  rsuStrobes_t strobes;

  rsuCtrl u_ctrl (
    .funcSel (funcSel),
    .rotSel  (rotSel),
    .skipSel (skipSel),
    .strobes (strobes)
  );

  rsuDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .skipNext (skipNext)
  );
endmodule

// File: rtl/rsuChecker.sv
module rsuChecker #(
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [2:0]        funcSel,
  input logic [1:0]        rotSel,
  input logic [1:0]        skipSel,
  input logic [DATA_W-1:0] result,
  input logic              skipNext
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (result == '0 && !skipNext));

  // R6
  neg_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel <= 3'd4 && skipSel == 2'd1) |=> (skipNext == result[DATA_W-1]));

  // R7
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel <= 3'd4 && skipSel == 2'd2) |=> (skipNext == (result == '0)));

  // R8
  never_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipSel == 2'd0 || skipSel == 2'd3) |=> !skipNext);

  // R9
  unused_func_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel > 3'd4) |=> (result == '0 && !skipNext));

  // R3
  and_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'd2 && rotSel == 2'd0) |=> (result == ($past(opA) & $past(opB))));

  // R4
  inc_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'd3 && rotSel == 2'd0) |=> (result == $past(opA) + 1'b1));

  // R4
  dec_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'd4 && rotSel == 2'd0) |=> (result == $past(opA) - 1'b1));
endmodule

bind rotSkipUnit rsuChecker #(.DATA_W(DATA_W)) u_rsuChecker (
  .clk      (clk),
  .rstN     (rstN),
  .opA      (opA),
  .opB      (opB),
  .funcSel  (funcSel),
  .rotSel   (rotSel),
  .skipSel  (skipSel),
  .result   (result),
  .skipNext (skipNext)
);

// File: tb/tb_rotSkipUnit.sv
module tb_rotSkipUnit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NPAIR = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   funcSel = '0;
  logic [1:0]   rotSel = '0;
  logic [1:0]   skipSel = '0;
  logic [W-1:0] result;
  logic         skipNext;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [W-1:0] pairA [NPAIR];
  logic [W-1:0] pairB [NPAIR];

  rotSkipUnit #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .funcSel(funcSel), .rotSel(rotSel), .skipSel(skipSel),
    .result(result), .skipNext(skipNext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int n);
    if (n == 0) return v;
    return (v >> n) | (v << (W - n));
  endfunction

  function automatic logic [W-1:0] expWord(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input int f, input int r);
    logic [W-1:0] v;
    int amt;
    case (f)
      0: v = a + b;
      1: v = a - b;
      2: v = a & b;
      3: v = a + 1;
      4: v = a - 1;
      default: v = '0;
    endcase
    amt = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 8 : 16;
    return rotr(v, amt);
  endfunction

  function automatic bit expSkip(input logic [W-1:0] v, input int f, input int s);
    if (f > 4) return 1'b0;
    if (s == 1) return v[W-1];
    if (s == 2) return v == '0;
    return 1'b0;
  endfunction

  task automatic checkWord(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s result: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s skipNext: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic applyOp(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int f, input int r, input int s);
    @(negedge clk);
    opA = a; opB = b;
    funcSel = 3'(f); rotSel = 2'(r); skipSel = 2'(s);
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [W-1:0] ew;
    string tw, ts;
    pairA[0] = 32'd0;          pairB[0] = 32'd0;
    pairA[1] = 32'd1;          pairB[1] = 32'd1;
    pairA[2] = 32'd5;          pairB[2] = 32'd5;
    pairA[3] = 32'hFFFF_FFFF;  pairB[3] = 32'd1;
    pairA[4] = 32'h8000_0000;  pairB[4] = 32'h7FFF_FFFF;
    pairA[5] = 32'h1234_5678;  pairB[5] = 32'hF0F0_0F0F;
    pairA[6] = 32'd3;          pairB[6] = 32'd10;
    pairA[7] = 32'h00FF_0001;  pairB[7] = 32'hDEAD_BEEF;

    // R1: reset state, with nonzero stimulus on the inputs
    opA = 32'hFFFF_FFFF; funcSel = 3'd3;
    repeat (3) @(posedge clk);
    #1;
    checkWord("R1", result, '0);
    checkBit("R1", skipNext, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // R5: a value of 1 rotated right by one
    applyOp(32'd1, 32'd1, 2, 1, 0);
    checkWord("R5", result, 32'h8000_0000);

    // R2: outputs hold between edges, and change after the next edge
    applyOp(32'd7, 32'd9, 0, 0, 0);
    @(negedge clk);
    opA = 32'd100; opB = 32'd1; funcSel = 3'd1;
    #1;
    checkWord("R2", result, 32'd16);
    @(posedge clk); #1;
    checkWord("R2", result, 32'd99);

    // Sweep over functions, rotations, skip selects and operand pairs
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < NPAIR; p++) begin
            applyOp(pairA[p], pairB[p], f, r, s);
            ew = expWord(pairA[p], pairB[p], f, r);
            tw = (f > 4) ? "R9" : (r != 0) ? "R5" : (f >= 3) ? "R4" : "R3";
            ts = (f > 4) ? "R9" : (s == 1) ? "R6" : (s == 2) ? "R7" : "R8";
            checkWord(tw, result, ew);
            checkBit(ts, skipNext, expSkip(ew, f, s));
          end

    // R4: opB has no effect on increment and decrement
    for (int f = 3; f < 5; f++) begin
      applyOp(32'h0000_0010, 32'h0, f, 0, 2);
      ew = result;
      applyOp(32'h0000_0010, 32'hFFFF_FFFF, f, 0, 2);
      checkWord("R4", result, ew);
      checkWord("R4", result, (f == 3) ? 32'h11 : 32'h0F);
    end

    // R1: reset asserted mid-run clears the outputs
    applyOp(32'hFFFF_FFFF, 32'd0, 0, 0, 1);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    checkWord("R1", result, '0);
    checkBit("R1", skipNext, 1'b0);

    finish();
  end
endmodule